// File: doc/BRIEF.md
# Framebuffer control register bank

This block is the register file of a simple 8-bit indexed-colour framebuffer controller. A host reaches it through a 32-bit word-access port that covers a 1.5 MB control window. The bank stores the screen geometry, the top-of-screen offset, a control word and the cursor position. It also holds a 256-entry RGB colour palette and a 3-entry cursor palette.

Geometry values are rescaled when they are stored. Width is kept in pixels but is programmed in units of four. Height is programmed in half-lines. A group of video timing offsets accepts writes and discards them.

The bank drives a refresh interrupt that the display side raises at the end of every frame. Any host write drops that interrupt. A dedicated soft-reset offset wipes the palette and the geometry. A one-cycle redraw pulse tells downstream display logic when a register that affects the picture has been written.

Top module: `fb_regbank`

## Requirements
- R1: After `rst_n` is released, all outputs are 0: `irq`, `redraw`, `rdata`, geometry, top, cursor position, `blank` and `cursor_off`.
- R2: A write to offset 0x118 stores `scr_width` as the written value times 4. A read of 0x118 returns `scr_width` divided by 4.
- R3: A write to offset 0x150 stores `scr_height` as the written value divided by 2, rounded down. A read of 0x150 returns `scr_height`.
- R4: Offset 0x300 holds a 32-bit control word that reads back unchanged. Bit 10 of that word drives `blank` and bit 23 drives `cursor_off`.
- R5: The top-of-screen offset (0x400) and the cursor position (0x638) are 32-bit registers. Each one reads back unchanged and is visible on `scr_top` and `cur_pos`.
- R6: Offsets 0x800 to 0xFFF form the colour palette. The entry index is (offset − 0x800) >> 3. Each entry packs R in bits 23:16, G in bits 15:8 and B in bits 7:0, and bits 31:24 read as 0.
- R7: The cursor palette has 3 entries at 0x508, 0x510 and 0x518. Each entry uses the same packing, with blue in bits 7:0.
- R8: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no stored state. Reads of these offsets return 0.
- R9: A read returns its data on `rdata` at the clock edge that follows `rd_en`. An unmapped offset reads 0. Address bits 1:0 are ignored.
- R10: `irq` rises on the edge after `frame_done`. Any write clears `irq`, and a write in the same cycle as `frame_done` leaves `irq` low.
- R11: A write to offset 0x100000 clears the colour palette, the top offset, the width, the height and `irq`. The control word, the cursor position and the cursor palette are kept.
- R12: `redraw` is high for exactly one cycle after each write to the top offset, the control word, the colour palette or the cursor palette. It stays low after any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| rd_en | input | 1 | Word read strobe |
| addr | input | AW | Byte offset into the control window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| frame_done | input | 1 | End-of-refresh pulse from display logic |
| irq | output | 1 | Refresh interrupt |
| redraw | output | 1 | One-cycle redraw request |
| scr_width | output | 32 | Stored width in pixels |
| scr_height | output | 32 | Stored height in lines |
| scr_top | output | 32 | Top-of-screen offset |
| cur_pos | output | 32 | Cursor position |
| blank | output | 1 | Forced blank |
| cursor_off | output | 1 | Hardware cursor disabled |

## Verification
A host write and an end-of-frame pulse can arrive in the same cycle. In that case the write must win, so the interrupt stays low. The bench drives `wr_en` and `frame_done` on the same falling edge and checks `irq` one cycle later. It also checks that a lone `frame_done` raises `irq` and that a following write drops it. A soft reset that lands in the same cycle as `frame_done` is checked the same way.

// File: rtl/fb_regbank.sv
module fb_regbank #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          frame_done,
  output logic          irq,
  output logic          redraw,
  output logic [31:0]   scr_width,
  output logic [31:0]   scr_height,
  output logic [31:0]   scr_top,
  output logic [31:0]   cur_pos,
  output logic          blank,
  output logic          cursor_off
);
  localparam logic [AW-1:0] OFF_WID  = AW'('h118);
  localparam logic [AW-1:0] OFF_HGT  = AW'('h150);
  localparam logic [AW-1:0] OFF_CTL  = AW'('h300);
  localparam logic [AW-1:0] OFF_TOP  = AW'('h400);
  localparam logic [AW-1:0] OFF_CPL0 = AW'('h508);
  localparam logic [AW-1:0] OFF_CPL2 = AW'('h518);
  localparam logic [AW-1:0] OFF_CPOS = AW'('h638);
  localparam logic [AW-1:0] OFF_PAL  = AW'('h800);
  localparam logic [AW-1:0] OFF_PEND = AW'('h1000);
  localparam logic [AW-1:0] OFF_SRST = AW'('h100000);
  localparam int PAL_N = 256;
  localparam int CPL_N = 3;

  logic [23:0] pal  [PAL_N];
  logic [23:0] cpal [CPL_N];
  logic [31:0] ctrl;

  wire [AW-1:0] off    = addr & ~AW'(3);
  wire          pal_hit = (off >= OFF_PAL) && (off < OFF_PEND);
  wire [7:0]    pal_idx = off[10:3];
  wire          cpl_hit = (off >= OFF_CPL0) && (off <= OFF_CPL2) && (off[2:0] == 3'd0);
  wire [1:0]    cpl_idx = off[4:3] - 2'd1;
  wire          pic_wr  = pal_hit || cpl_hit || off == OFF_TOP || off == OFF_CTL;

  assign blank      = ctrl[10];
  assign cursor_off = ctrl[23];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAL_N; i++) pal[i] <= '0;
      for (int i = 0; i < CPL_N; i++) cpal[i] <= '0;
      ctrl <= '0; scr_width <= '0; scr_height <= '0;
      scr_top <= '0; cur_pos <= '0;
      irq <= 1'b0; redraw <= 1'b0;
    end else begin
      redraw <= wr_en && pic_wr;
      if (wr_en) irq <= 1'b0;
      else if (frame_done) irq <= 1'b1;
      if (wr_en) begin
        if (pal_hit) pal[pal_idx] <= wdata[23:0];
        if (cpl_hit) cpal[cpl_idx] <= wdata[23:0];
        case (off)
          OFF_WID:  scr_width  <= wdata << 2;
          OFF_HGT:  scr_height <= wdata >> 1;
          OFF_CTL:  ctrl       <= wdata;
          OFF_TOP:  scr_top    <= wdata;
          OFF_CPOS: cur_pos    <= wdata;
          OFF_SRST: begin
            for (int i = 0; i < PAL_N; i++) pal[i] <= '0;
            scr_top <= '0; scr_width <= '0; scr_height <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (pal_hit) rd_mux = {8'h0, pal[pal_idx]};
    else if (cpl_hit) rd_mux = {8'h0, cpal[cpl_idx]};
    else begin
      case (off)
        OFF_WID:  rd_mux = scr_width >> 2;
        OFF_HGT:  rd_mux = scr_height;
        OFF_CTL:  rd_mux = ctrl;
        OFF_TOP:  rd_mux = scr_top;
        OFF_CPOS: rd_mux = cur_pos;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R10
  irq_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq);
  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !wr_en) |=> irq);
  // R12
  redraw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redraw |-> $past(wr_en));
  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_SRST) |=> (scr_width == 0 && scr_height == 0 && scr_top == 0 && !irq));
  // R2
  width_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_WID) |=> (scr_width[1:0] == 2'b00));
endmodule

// File: tb/sim_fb_regbank.sv
module sim_fb_regbank;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, frame_done = 0;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, scr_width, scr_height, scr_top, cur_pos;
  logic irq, redraw, blank, cursor_off;
  int n_chk = 0, n_bad = 0;
  logic done = 0;

  fb_regbank #(.AW(21)) u0 (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .frame_done, .irq, .redraw, .scr_width, .scr_height, .scr_top, .cur_pos,
    .blank, .cursor_off);

  always #10 clk = ~clk;

  logic [23:0] m_pal [256];
  logic [23:0] m_cpl [3];
  logic [31:0] m_w, m_h, m_top, m_ctl, m_pos;

  localparam logic [20:0] IGN [14] = '{21'h000, 21'h108, 21'h110, 21'h120, 21'h128,
    21'h130, 21'h138, 21'h140, 21'h148, 21'h158, 21'h160, 21'h168, 21'h170, 21'h200};

  function automatic logic [31:0] exp_rd(logic [20:0] a);
    logic [20:0] o = a & ~21'd3;
    if (o >= 21'h800 && o < 21'h1000) return {8'h0, m_pal[o[10:3]]};
    if (o == 21'h508) return {8'h0, m_cpl[0]};
    if (o == 21'h510) return {8'h0, m_cpl[1]};
    if (o == 21'h518) return {8'h0, m_cpl[2]};
    case (o)
      21'h118: return m_w >> 2;
      21'h150: return m_h;
      21'h300: return m_ctl;
      21'h400: return m_top;
      21'h638: return m_pos;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_redraw(logic [20:0] a);
    logic [20:0] o = a & ~21'd3;
    return (o >= 21'h800 && o < 21'h1000) || o == 21'h508 || o == 21'h510 ||
           o == 21'h518 || o == 21'h400 || o == 21'h300;
  endfunction

  task automatic model_wr(logic [20:0] a, logic [31:0] d);
    logic [20:0] o = a & ~21'd3;
    if (o >= 21'h800 && o < 21'h1000) m_pal[o[10:3]] = d[23:0];
    else if (o == 21'h508) m_cpl[0] = d[23:0];
    else if (o == 21'h510) m_cpl[1] = d[23:0];
    else if (o == 21'h518) m_cpl[2] = d[23:0];
    else case (o)
      21'h118: m_w = d << 2;
      21'h150: m_h = d >> 1;
      21'h300: m_ctl = d;
      21'h400: m_top = d;
      21'h638: m_pos = d;
      21'h100000: begin
        for (int i = 0; i < 256; i++) m_pal[i] = '0;
        m_w = 0; m_h = 0; m_top = 0;
      end
      default: ;
    endcase
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [20:0] a, logic [31:0] d, logic fd = 0);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; frame_done = fd;
    @(negedge clk); wr_en = 0; frame_done = 0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(logic [20:0] a, string req);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    check(req, rdata, exp_rd(a));
  endtask

  task automatic outs_chk(string req);
    check(req, scr_width, m_w);
    check(req, scr_height, m_h);
    check(req, scr_top, m_top);
    check(req, cur_pos, m_pos);
    check(req, {30'h0, blank, cursor_off}, {30'h0, m_ctl[10], m_ctl[23]});
  endtask

  function automatic logic [20:0] pick();
    case ($urandom_range(0, 9))
      0: return 21'h118;
      1: return 21'h150;
      2: return 21'h300;
      3: return 21'h400;
      4: return 21'h638;
      5: return 21'h508 + 21'(8 * $urandom_range(0, 2));
      6, 7: return 21'h800 + 21'($urandom_range(0, 'h7FF));
      8: return IGN[$urandom_range(0, 13)];
      default: return 21'($urandom_range(0, 'h1FFF)) | 21'h1000;
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) m_pal[i] = '0;
    for (int i = 0; i < 3; i++) m_cpl[i] = '0;
    m_w = 0; m_h = 0; m_top = 0; m_ctl = 0; m_pos = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1", {irq, redraw}, 2'b00);
    check("R1", rdata, 0);
    outs_chk("R1");

    // R2
    wr(21'h118, 32'd160);
    check("R2", scr_width, 32'd640);
    rd_chk(21'h118, "R2");
    wr(21'h118, 32'hC000_0005);
    check("R2", scr_width, 32'd20);
    rd_chk(21'h11B, "R2 R9");
    // R3
    wr(21'h150, 32'd961);
    check("R3", scr_height, 32'd480);
    rd_chk(21'h150, "R3");
    // R4
    wr(21'h300, 32'h0000_0400);
    check("R4", {blank, cursor_off}, 2'b10);
    wr(21'h300, 32'h0080_0000);
    check("R4", {blank, cursor_off}, 2'b01);
    rd_chk(21'h300, "R4");
    // R5
    wr(21'h400, 32'h0001_2340);
    wr(21'h638, 32'h0123_0456);
    outs_chk("R5");
    rd_chk(21'h400, "R5"); rd_chk(21'h638, "R5");
    // R6
    wr(21'h800, 32'hFFAA_BBCC);
    wr(21'hFFC, 32'h0011_2233);
    wr(21'h80C, 32'h0044_5566);
    rd_chk(21'h800, "R6"); rd_chk(21'hFF8, "R6"); rd_chk(21'h808, "R6");
    check("R6", exp_rd(21'h800), 32'h00AA_BBCC);
    // R7
    wr(21'h508, 32'h0000_00FF); wr(21'h510, 32'h00FF_0000); wr(21'h518, 32'h0000_FF00);
    rd_chk(21'h508, "R7"); rd_chk(21'h510, "R7"); rd_chk(21'h518, "R7");
    // R8
    for (int i = 0; i < 14; i++) begin
      wr(IGN[i], 32'hFFFF_FFFF);
      check("R8", {31'h0, redraw}, 0);
      rd_chk(IGN[i], "R8");
    end
    outs_chk("R8");
    rd_chk(21'h118, "R8"); rd_chk(21'h300, "R8");
    // R9
    rd_chk(21'h1004, "R9"); rd_chk(21'h0FF000, "R9"); rd_chk(21'h520, "R9");
    // R10
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
    check("R10", {31'h0, irq}, 1);
    wr(21'h638, 32'h77);
    check("R10", {31'h0, irq}, 0);
    wr(21'h000, 32'h0, 1'b1);
    check("R10 same-cycle", {31'h0, irq}, 0);
    // R12
    wr(21'h400, 32'h1000);
    check("R12", {31'h0, redraw}, 1);
    @(negedge clk);
    check("R12", {31'h0, redraw}, 0);
    wr(21'h638, 32'h5);
    check("R12", {31'h0, redraw}, 0);
    // R11
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
    wr(21'h100000, 32'h0, 1'b1);
    check("R11", {31'h0, irq}, 0);
    outs_chk("R11");
    rd_chk(21'h800, "R11"); rd_chk(21'hFF8, "R11"); rd_chk(21'h300, "R11");
    rd_chk(21'h508, "R11"); rd_chk(21'h638, "R11");

    for (int i = 0; i < 400; i++) begin
      logic [20:0] a = pick();
      logic [31:0] d = $urandom;
      wr(a, d);
      check("R12 rnd", {31'h0, redraw}, {31'h0, exp_redraw(a)});
      rd_chk(pick(), "R2-R9 rnd");
      if (i % 50 == 49) outs_chk("R5 rnd");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule